// File: doc/BRIEF.md
# Banked Interrupt Control Unit

This block gathers interrupt requests from a large set of on-chip sources and presents them to a processor as a small number of request lines. The sources are split into identical banks of 32 lines. Every bank latches request edges into a pending register, holds a per-line enable register, and raises one registered request line toward the CPU whenever a pending line is also enabled.

Software sees each bank as a group of five 32-bit registers on a simple register bus. The groups repeat at a fixed byte stride. Pending bits are cleared by writing ones to them. For the interrupt handler's fast path, every bank also provides the index of its highest-numbered line that is both pending and enabled, which is the line to service first.

Top module: `banked_irq_ctrl`

## Requirements
- R1: A pending bit is set on a clock where its source input is 1 and was 0 on the previous clock. A source that stays high does not set the bit again after it has been cleared.
- R2: Bank b occupies byte addresses b*0x28 up to b*0x28+0x27. Within a bank the registers sit at these offsets: pending 0x00, enable 0x08, enabled-pending 0x10, raw pending 0x18, inverted enable 0x20. A read of any other offset, or of an address beyond the last bank, returns 0. A write to one bank leaves the other banks unchanged.
- R3: Writing the pending register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: The register at offset 0x10 reads as pending AND enable, and writes to it are ignored. A bank whose pending AND enable is zero holds its CPU request low.
- R5: The enable register is read/write and resets to 0.
- R6: When pending AND enable is non-zero, the bank reports valid=1 and the index of its highest set bit. Otherwise valid is 0.
- R7: The register at offset 0x18 reads the pending bits regardless of enable. The register at offset 0x20 reads as the bitwise inverse of enable, and writing value v to it sets enable to ~v.
- R8: If a source edge and a clearing write hit the same bit in the same clock, the bit ends up set.
- R9: The CPU request of a bank is registered. It changes one clock after the pending or enable change that causes it.
- R10: Read data appears on the read-data port on the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | NB*LINES | Request inputs; bank b uses bits b*LINES and above |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, registered |
| cpu_irq_o | output | NB | One registered request line per bank |
| top_line_o | output | NB*IDX_W | Highest enabled pending index for each bank |
| top_vld_o | output | NB | Index-valid flag for each bank |

## Verification
Two events can collide in a single clock: a source edge that sets a pending bit, and a software write-one-to-clear aimed at the same bit. The bench provokes this collision by raising a source input and issuing the clearing write in the same cycle. A later read of the pending register must show that bit still set. A second timing overlap is also checked: a clear-all write lands while the registered CPU request is high, and the request must stay high for exactly one further clock before it drops.

// File: rtl/icu_pkg.sv
package icu_pkg;

   typedef enum logic [2:0] {
      RSEL_NONE,
      RSEL_STAT,
      RSEL_EN,
      RSEL_OUT,
      RSEL_RAW,
      RSEL_MASK
   } icu_rsel_e;

   localparam logic [7:0] OFF_STAT = 8'h00;
   localparam logic [7:0] OFF_EN   = 8'h08;
   localparam logic [7:0] OFF_OUT  = 8'h10;
   localparam logic [7:0] OFF_RAW  = 8'h18;
   localparam logic [7:0] OFF_MASK = 8'h20;

   function automatic icu_rsel_e decode_off(input logic [7:0] off);
      icu_rsel_e s;
      case (off)
         OFF_STAT: s = RSEL_STAT;
         OFF_EN:   s = RSEL_EN;
         OFF_OUT:  s = RSEL_OUT;
         OFF_RAW:  s = RSEL_RAW;
         OFF_MASK: s = RSEL_MASK;
         default:  s = RSEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/icu_addr_decode.sv
module icu_addr_decode
   import icu_pkg::*;
#(
   parameter int unsigned NB     = 5,
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned STRIDE = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NB-1:0]     hit_o,
   output icu_rsel_e         sel_o
);

   localparam int unsigned EW = ADDR_W + 1;

   generate
      if (STRIDE <= 32 || STRIDE > 256) begin : g_bad_stride
         $error("icu_addr_decode: STRIDE must exceed 0x20 and fit in 8 bits");
      end
      if (NB * STRIDE > (1 << ADDR_W)) begin : g_bad_addr
         $error("icu_addr_decode: ADDR_W too small for NB banks");
      end
   endgenerate

   logic [EW-1:0] a_ext;
   logic [7:0]    off_part [NB];
   logic [7:0]    off;

   assign a_ext = {1'b0, addr_i};

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank_win
         localparam logic [EW-1:0] BASE = EW'(b * STRIDE);
         localparam logic [EW-1:0] LIM  = EW'((b + 1) * STRIDE);
         logic [EW-1:0] rel;
         assign rel         = a_ext - BASE;
         assign hit_o[b]    = (a_ext >= BASE) && (a_ext < LIM);
         assign off_part[b] = hit_o[b] ? rel[7:0] : 8'h00;
      end
   endgenerate

   always_comb begin
      off = 8'h00;
      for (int b = 0; b < NB; b++) off = off | off_part[b];
   end

   assign sel_o = (|hit_o) ? decode_off(off) : RSEL_NONE;

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_o)); // R2

endmodule

// File: rtl/icu_msb_find.sv
module icu_msb_find #(
   parameter int unsigned W     = 32,
   parameter int unsigned IDX_W = 5,
   parameter bit          TREE  = 1'b0
) (
   input  logic [W-1:0]     vec_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             vld_o
);

   generate
      if (W > (1 << IDX_W)) begin : g_bad_w
         $error("icu_msb_find: IDX_W cannot index W lines");
      end
   endgenerate

   generate
      if (!TREE) begin : g_scan
         always_comb begin
            idx_o = '0;
            vld_o = 1'b0;
            for (int i = 0; i < W; i++) begin
               if (vec_i[i]) begin
                  idx_o = IDX_W'(i);
                  vld_o = 1'b1;
               end
            end
         end
      end else begin : g_isolate
         logic [W-1:0] rev;
         logic [W-1:0] lowest;
         always_comb begin
            for (int i = 0; i < W; i++) rev[i] = vec_i[W-1-i];
         end
         assign lowest = rev & (~rev + W'(1));
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < W; i++) begin
               if (lowest[i]) idx_o = idx_o | IDX_W'(W - 1 - i);
            end
         end
         assign vld_o = |vec_i;
      end
   endgenerate

endmodule

// File: rtl/icu_bank.sv
module icu_bank #(
   parameter int unsigned LINES    = 32,
   parameter int unsigned IDX_W    = 5,
   parameter bit          ENC_TREE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] src_i,
   input  logic             wr_stat_i,
   input  logic             wr_en_i,
   input  logic             wr_mask_i,
   input  logic [LINES-1:0] wdata_i,
   output logic [LINES-1:0] pending_o,
   output logic [LINES-1:0] enable_o,
   output logic             irq_o,
   output logic [IDX_W-1:0] top_idx_o,
   output logic             top_vld_o
);

   logic [LINES-1:0] src_q;
   logic [LINES-1:0] rise;
   logic [LINES-1:0] clr;
   logic [LINES-1:0] pending;
   logic [LINES-1:0] enable;
   logic [LINES-1:0] outv;

   assign rise = src_i & ~src_q;
   assign clr  = wr_stat_i ? wdata_i : '0;
   assign outv = pending & enable;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q   <= '0;
         pending <= '0;
      end else begin
         src_q   <= src_i;
         pending <= (pending & ~clr) | rise;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable <= '0;
      end else if (wr_en_i) begin
         enable <= wdata_i;
      end else if (wr_mask_i) begin
         enable <= ~wdata_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |outv;
   end

   icu_msb_find #(
      .W     (LINES),
      .IDX_W (IDX_W),
      .TREE  (ENC_TREE)
   ) u_msb (
      .vec_i (outv),
      .idx_o (top_idx_o),
      .vld_o (top_vld_o)
   );

   assign pending_o = pending;
   assign enable_o  = enable;

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat_i |=> ((pending & $past(wdata_i & ~rise)) == '0)); // R3
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((pending & $past(rise)) == $past(rise))); // R8
   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pending & ~$past(pending) & ~$past(rise)) == '0)); // R1
   AST_TOP_IS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      top_vld_o |-> ((outv >> top_idx_o) == LINES'(1))); // R6
   AST_TOP_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      !top_vld_o |-> (outv == '0)); // R6

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
   import icu_pkg::*;
#(
   parameter int unsigned NB       = 5,
   parameter int unsigned LINES    = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned STRIDE   = 40,
   parameter bit          ENC_TREE = 1'b0,
   localparam int unsigned IDX_W   = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NB*LINES-1:0] irq_src_i,
   input  logic                bus_wr_i,
   input  logic                bus_rd_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   output logic [NB-1:0]       cpu_irq_o,
   output logic [NB*IDX_W-1:0] top_line_o,
   output logic [NB-1:0]       top_vld_o
);

   generate
      if (LINES != DATA_W) begin : g_bad_lines
         $error("banked_irq_ctrl: LINES must equal DATA_W");
      end
      if (NB < 1) begin : g_bad_nb
         $error("banked_irq_ctrl: NB must be at least 1");
      end
   endgenerate

   logic [NB-1:0]    hit;
   icu_rsel_e        sel;
   logic [LINES-1:0] pend_a [NB];
   logic [LINES-1:0] en_a   [NB];
   logic [DATA_W-1:0] rd_mux;

   icu_addr_decode #(
      .NB     (NB),
      .ADDR_W (ADDR_W),
      .STRIDE (STRIDE)
   ) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_i (bus_addr_i),
      .hit_o  (hit),
      .sel_o  (sel)
   );

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         logic wr_sel;
         assign wr_sel = bus_wr_i && hit[b];
         icu_bank #(
            .LINES    (LINES),
            .IDX_W    (IDX_W),
            .ENC_TREE (ENC_TREE)
         ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (irq_src_i[b*LINES +: LINES]),
            .wr_stat_i (wr_sel && (sel == RSEL_STAT)),
            .wr_en_i   (wr_sel && (sel == RSEL_EN)),
            .wr_mask_i (wr_sel && (sel == RSEL_MASK)),
            .wdata_i   (bus_wdata_i),
            .pending_o (pend_a[b]),
            .enable_o  (en_a[b]),
            .irq_o     (cpu_irq_o[b]),
            .top_idx_o (top_line_o[b*IDX_W +: IDX_W]),
            .top_vld_o (top_vld_o[b])
         );
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NB; b++) begin
         if (hit[b]) begin
            case (sel)
               RSEL_STAT, RSEL_RAW: rd_mux = pend_a[b];
               RSEL_EN:             rd_mux = en_a[b];
               RSEL_OUT:            rd_mux = pend_a[b] & en_a[b];
               RSEL_MASK:           rd_mux = ~en_a[b];
               default:             rd_mux = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        bus_rdata_o <= '0;
      else if (bus_rd_i) bus_rdata_o <= rd_mux;
   end

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && (hit == '0)) |=> (bus_rdata_o == '0)); // R2
   AST_BAD_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && (sel == RSEL_NONE)) |=> (bus_rdata_o == '0)); // R2

endmodule

// File: tb/tb_banked_irq_ctrl.sv
`timescale 1ns/1ps
module tb_banked_irq_ctrl;

   localparam int NB = 5;
   localparam int LINES = 32;
   localparam int IDX_W = 5;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NB*LINES-1:0] src = '0;
   logic                bus_wr = 1'b0;
   logic                bus_rd = 1'b0;
   logic [11:0]         bus_addr = '0;
   logic [31:0]         bus_wdata = '0;
   logic [31:0]         bus_rdata;
   logic [NB-1:0]       cpu_irq;
   logic [NB*IDX_W-1:0] top_line;
   logic [NB-1:0]       top_vld;

   always #2 clk = ~clk;

   banked_irq_ctrl dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_src_i   (src),
      .bus_wr_i    (bus_wr),
      .bus_rd_i    (bus_rd),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .cpu_irq_o   (cpu_irq),
      .top_line_o  (top_line),
      .top_vld_o   (top_vld)
   );

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   errors = 0;
   int   checks = 0;
   logic rd_seen = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: read data is due one clock after the strobe (R10)
   always @(posedge clk) rd_seen <= bus_rd;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (sb.size() == 0) begin
            chk("R10 unexpected read data", 32'h1, 32'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, bus_rdata, e.exp);
         end
      end
   end

   function automatic logic [11:0] ra(input int bank, input int off);
      return 12'(bank * 40 + off);
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      exp_t e;
      @(negedge clk);
      e.exp = exp; e.tag = tag;
      sb.push_back(e);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse(input int idx);
      @(negedge clk);
      src[idx] = 1'b1;
      @(negedge clk);
      src[idx] = 1'b0;
   endtask

   task automatic finish_run();
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(ra(0, 8'h08), 32'h0, "R5 enable after reset");
      rd(ra(0, 8'h20), 32'hFFFF_FFFF, "R7 inverted enable after reset");
      rd(ra(0, 8'h00), 32'h0, "R1 pending after reset");
      chk("R4 no request after reset", 32'(cpu_irq), 32'h0);

      // edges latch, enable still off
      pulse(3);
      pulse(17);
      rd(ra(0, 8'h00), 32'h0002_0008, "R1 pending after two pulses");
      rd(ra(0, 8'h18), 32'h0002_0008, "R7 raw pending");
      rd(ra(0, 8'h10), 32'h0, "R4 enabled-pending with enable off");
      chk("R4 request low while disabled", 32'(cpu_irq[0]), 32'h0);
      chk("R6 no valid while disabled", 32'(top_vld[0]), 32'h0);

      // enable both lines: request follows one clock later
      wr(ra(0, 8'h08), 32'h0002_0008);
      chk("R9 request not yet raised", 32'(cpu_irq[0]), 32'h0);
      @(negedge clk);
      chk("R9 request raised one clock later", 32'(cpu_irq[0]), 32'h1);
      chk("R6 highest line 17", 32'(top_line[IDX_W-1:0]), 32'd17);
      chk("R6 valid", 32'(top_vld[0]), 32'h1);
      rd(ra(0, 8'h10), 32'h0002_0008, "R4 enabled-pending");

      // write-one-to-clear
      wr(ra(0, 8'h00), 32'h0002_0000);
      rd(ra(0, 8'h00), 32'h0000_0008, "R3 clear bit 17 only");
      chk("R6 highest line now 3", 32'(top_line[IDX_W-1:0]), 32'd3);
      wr(ra(0, 8'h00), 32'h0);
      rd(ra(0, 8'h00), 32'h0000_0008, "R3 zero write keeps bits");

      // edge and clear on the same bit in the same clock
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = ra(0, 8'h00); bus_wdata = 32'h0000_0020;
      src[5] = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; src[5] = 1'b0;
      rd(ra(0, 8'h00), 32'h0000_0028, "R8 set beats clear");

      // inverted-enable write
      wr(ra(0, 8'h20), 32'hFFFF_FFDF);
      rd(ra(0, 8'h08), 32'h0000_0020, "R7 mask write sets enable");
      rd(ra(0, 8'h10), 32'h0000_0020, "R4 enabled-pending after mask write");
      chk("R6 highest line 5", 32'(top_line[IDX_W-1:0]), 32'd5);

      // write to enabled-pending register is ignored
      wr(ra(0, 8'h10), 32'hFFFF_FFFF);
      rd(ra(0, 8'h00), 32'h0000_0028, "R4 write to 0x10 ignored (pending)");
      rd(ra(0, 8'h08), 32'h0000_0020, "R4 write to 0x10 ignored (enable)");

      // other banks at stride 0x28
      wr(ra(3, 8'h08), 32'hA5A5_0000);
      rd(ra(3, 8'h08), 32'hA5A5_0000, "R2 bank 3 enable");
      rd(ra(2, 8'h08), 32'h0, "R2 bank 2 untouched");
      rd(ra(4, 8'h08), 32'h0, "R2 bank 4 untouched");
      pulse(3 * 32 + 31);
      pulse(4 * 32 + 0);
      rd(ra(3, 8'h00), 32'h8000_0000, "R2 bank 3 pending");
      rd(ra(4, 8'h00), 32'h0000_0001, "R2 bank 4 pending");
      chk("R4 bank 3 request", 32'(cpu_irq[3]), 32'h1);
      chk("R4 bank 4 request low", 32'(cpu_irq[4]), 32'h0);
      chk("R6 bank 3 highest line 31", 32'(top_line[3*IDX_W +: IDX_W]), 32'd31);
      rd(12'd200, 32'h0, "R2 address past last bank");
      rd(ra(0, 8'h04), 32'h0, "R2 unused offset");

      // level held high: edge only, then clear-all with request timing
      @(negedge clk);
      src[9] = 1'b1;
      repeat (3) @(negedge clk);
      rd(ra(0, 8'h00), 32'h0000_0228, "R1 held level sets once");
      wr(ra(0, 8'h00), 32'hFFFF_FFFF);
      chk("R9 request still high right after clear", 32'(cpu_irq[0]), 32'h1);
      @(negedge clk);
      chk("R4 request drops after clear-all", 32'(cpu_irq[0]), 32'h0);
      rd(ra(0, 8'h00), 32'h0, "R1 held level does not re-set");
      chk("R6 no valid after clear-all", 32'(top_vld[0]), 32'h0);
      src[9] = 1'b0;

      finish_run();
   end

endmodule